// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Register

This block is the arithmetic and logic unit of an 8-bit accumulator processor. It also holds the five-bit status flag register. Each accepted operation takes the accumulator value, an 8-bit operand and, for the wide add, a 16-bit register pair and the HL pair. It computes a result and updates the flags by the rules of that operation. Operand fetch, the register file and instruction decode are outside the block. The decoder routes `result` to the register it selected whenever `res_we` is high, and routes `hl_out` into HL whenever `hl_we` is high.

The block is built around a two-state machine. In ST_IDLE no result is presented. The transition ST_IDLE to ST_EMIT, and the self-loop ST_EMIT to ST_EMIT, are taken on every cycle where `in_valid` is high. The transitions ST_EMIT to ST_IDLE, and the self-loop ST_IDLE to ST_IDLE, are taken when `in_valid` is low. An accepted operation therefore appears on the outputs one clock later. In the same edge the flag register takes its new value. Back-to-back operations use the flags left by the operation before them.

Top module: `acc_alu`

## Requirements
- R1: After reset `out_valid` is 0 and all flags are 0. An operation presented with `in_valid` high appears with `out_valid` high exactly one clock later. `out_valid` is 0 in every cycle that follows a cycle without `in_valid`.
- R2: `flags` is laid out as bit 4 = sign, bit 3 = zero, bit 2 = auxiliary carry, bit 1 = parity, bit 0 = carry. Where an operation sets S, Z and P from its result, S is result bit 7, Z is 1 for a zero result, and P is 1 for an even count of ones.
- R3: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+CY. CY is the carry out of bit 7 and AC is the carry out of bit 3. The result is written.
- R4: Code 2 (subtract) gives A-B and code 3 (subtract with borrow) gives A-B-CY. CY is 1 when a borrow out of bit 7 occurs. AC is 1 when the low nibble needs a borrow. The result is written.
- R5: Code 4 (AND) sets AC=1. Code 5 (OR) and code 6 (XOR) clear AC. All three clear CY, set S/Z/P from the result, and write it.
- R6: Code 7 (compare) sets flags as A-B does: CY=1 and Z=0 when A<B, CY=0 and Z=1 when A=B, CY=0 and Z=0 when A>B. Nothing is written.
- R7: Code 8 (increment) and code 9 (decrement) act on the operand B. They set S, Z, P and AC from the result, write it, and leave CY unchanged.
- R8: Code 13 rotates A left and code 14 rotates A right, within its 8 bits, copying the bit that leaves into CY. Code 15 (left) and code 16 (right) rotate the 9-bit ring of A and CY. The result is written and S, Z, AC and P are kept.
- R9: Code 10 writes the inverse of A and keeps all flags. Code 11 sets CY to 1 and code 12 inverts CY. Neither of them writes a result or changes any other flag.
- R10: Code 17 (decimal adjust) first adds 0x06 if the low nibble of A exceeds 9 or AC=1. AC is then the carry out of bit 3 from that step. Next it adds 0x60 if the intermediate high nibble exceeds 9, or CY=1, or the first step overflowed. CY is then 1 exactly when this second step occurs. S/Z/P come from the result, and the result is written.
- R11: Code 18 adds the register pair to HL. It presents the 16-bit sum on `hl_out` with `hl_we` high and sets CY to the carry out of bit 15. All other flags are kept and `res_we` is low.
- R12: Codes 19 to 31 write nothing and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator value A |
| opnd_in | input | 8 | Operand B |
| pair_in | input | 16 | Register pair for the wide add |
| hl_in | input | 16 | HL pair for the wide add |
| out_valid | output | 1 | Outputs hold the result of the last accepted operation |
| result | output | 8 | 8-bit result |
| res_we | output | 1 | `result` must be written to its destination |
| hl_out | output | 16 | Wide-add sum |
| hl_we | output | 1 | `hl_out` must be written to HL |
| flags | output | 5 | Status flag register S,Z,AC,P,CY |

## Verification
The checker assumes that `in_valid` is low during reset. It also assumes that `op_code` is a stable, defined value in every cycle where `in_valid` is high, because the flag-preservation properties compare flags across the edge where the code was sampled. The bench drives all inputs on the falling edge, holds `in_valid` low through reset, and mixes back-to-back operations with idle gaps. Codes above 18 are sent only on purpose, to check that they are ignored.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int WIDE_W = 2 * DATA_W;
    localparam int CODE_W = 5;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_OR  = 5'd5,
        OP_XOR = 5'd6,
        OP_CMP = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_CMA = 5'd10,
        OP_STC = 5'd11,
        OP_CMC = 5'd12,
        OP_RLC = 5'd13,
        OP_RRC = 5'd14,
        OP_RAL = 5'd15,
        OP_RAR = 5'd16,
        OP_DAA = 5'd17,
        OP_DAD = 5'd18
    } op_e;

    typedef enum logic [1:0] {
        ROT_LEFT_RING  = 2'd0,
        ROT_RIGHT_RING = 2'd1,
        ROT_LEFT_CY    = 2'd2,
        ROT_RIGHT_CY   = 2'd3
    } rot_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    function automatic flags_t szp_flags(input logic [DATA_W-1:0] r,
                                         input logic ac, input logic cy);
        flags_t f;
        f.s  = r[DATA_W-1];
        f.z  = (r == '0);
        f.ac = ac;
        f.p  = ~^r;
        f.cy = cy;
        return f;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cy,
    output logic          hc
);
    localparam int HW = DW / 2;

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   full;
    logic [HW:0]   half;

    // Subtraction is done as a + ~b + ~borrow; carry flags are then inverted
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        half  = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        sum   = full[DW-1:0];
        cy    = full[DW] ^ sub;
        hc    = half[HW] ^ sub;
    end

endmodule

// File: rtl/alu_rotdaa.sv
module alu_rotdaa
    import acc_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic          cy_in,
    input  logic          ac_in,
    input  rot_e          rot_sel,
    output logic [DW-1:0] rot_res,
    output logic          rot_cy,
    output logic [DW-1:0] daa_res,
    output logic          daa_cy,
    output logic          daa_ac
);
    localparam int HW = DW / 2;
    localparam logic [HW-1:0] NIB_MAX = HW'(9);
    localparam logic [DW-1:0] LO_FIX  = DW'(6);
    localparam logic [DW-1:0] HI_FIX  = LO_FIX << HW;

    logic          lo_need;
    logic          hi_need;
    logic [DW:0]   step1;
    logic [HW:0]   lo_sum;

    always_comb begin
        unique case (rot_sel)
            ROT_LEFT_RING:  begin rot_res = {a[DW-2:0], a[DW-1]}; rot_cy = a[DW-1]; end
            ROT_RIGHT_RING: begin rot_res = {a[0], a[DW-1:1]};    rot_cy = a[0];    end
            ROT_LEFT_CY:    begin rot_res = {a[DW-2:0], cy_in};   rot_cy = a[DW-1]; end
            ROT_RIGHT_CY:   begin rot_res = {cy_in, a[DW-1:1]};   rot_cy = a[0];    end
        endcase
    end

    always_comb begin
        lo_need = (a[HW-1:0] > NIB_MAX) | ac_in;
        step1   = {1'b0, a} + {1'b0, (lo_need ? LO_FIX : '0)};
        lo_sum  = {1'b0, a[HW-1:0]} + {1'b0, (lo_need ? LO_FIX[HW-1:0] : '0)};
        daa_ac  = lo_sum[HW];
        hi_need = (step1[DW-1:HW] > NIB_MAX) | cy_in | step1[DW];
        daa_res = step1[DW-1:0] + (hi_need ? HI_FIX : '0);
        daa_cy  = hi_need;
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CODE_W-1:0]   op_code,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   opnd_in,
    input  logic [WIDE_W-1:0]   pair_in,
    input  logic [WIDE_W-1:0]   hl_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                res_we,
    output logic [WIDE_W-1:0]   hl_out,
    output logic                hl_we,
    output logic [4:0]          flags
);
    state_e state_q, state_d;
    flags_t flg_q, flg_d;
    op_e    op;

    logic [DATA_W-1:0] res_d;
    logic              we_d;
    logic [WIDE_W-1:0] hl_d;
    logic              hlwe_d;

    // main add/subtract/compare path
    logic              main_sub, main_cin;
    logic [DATA_W-1:0] main_sum;
    logic              main_cy, main_hc;
    // increment/decrement path on the operand
    logic [DATA_W-1:0] step_sum;
    logic              step_cy, step_hc;
    // wide add path
    logic [WIDE_W-1:0] wide_sum;
    logic              wide_cy, wide_hc;
    // rotate / decimal adjust
    rot_e              rot_sel;
    logic [DATA_W-1:0] rot_res, daa_res;
    logic              rot_cy, daa_cy, daa_ac;

    assign op = op_e'(op_code);

    always_comb begin
        main_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        main_cin = ((op == OP_ADC) || (op == OP_SBB)) ? flg_q.cy : 1'b0;
        unique case (op)
            OP_RRC:  rot_sel = ROT_RIGHT_RING;
            OP_RAL:  rot_sel = ROT_LEFT_CY;
            OP_RAR:  rot_sel = ROT_RIGHT_CY;
            default: rot_sel = ROT_LEFT_RING;
        endcase
    end

    alu_addsub #(.DW(DATA_W)) u_main (
        .a(acc_in), .b(opnd_in), .cin(main_cin), .sub(main_sub),
        .sum(main_sum), .cy(main_cy), .hc(main_hc)
    );

    alu_addsub #(.DW(DATA_W)) u_step (
        .a(opnd_in), .b(DATA_W'(1)), .cin(1'b0), .sub(op == OP_DEC),
        .sum(step_sum), .cy(step_cy), .hc(step_hc)
    );

    alu_addsub #(.DW(WIDE_W)) u_wide (
        .a(hl_in), .b(pair_in), .cin(1'b0), .sub(1'b0),
        .sum(wide_sum), .cy(wide_cy), .hc(wide_hc)
    );

    alu_rotdaa #(.DW(DATA_W)) u_rot (
        .a(acc_in), .cy_in(flg_q.cy), .ac_in(flg_q.ac), .rot_sel(rot_sel),
        .rot_res(rot_res), .rot_cy(rot_cy),
        .daa_res(daa_res), .daa_cy(daa_cy), .daa_ac(daa_ac)
    );

    // per-operation result and flag rules
    always_comb begin
        flg_d  = flg_q;
        res_d  = acc_in;
        we_d   = 1'b0;
        hl_d   = wide_sum;
        hlwe_d = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res_d = main_sum;
                we_d  = 1'b1;
                flg_d = szp_flags(main_sum, main_hc, main_cy);
            end
            OP_CMP: begin
                res_d = main_sum;
                flg_d = szp_flags(main_sum, main_hc, main_cy);
            end
            OP_AND: begin
                res_d = acc_in & opnd_in;
                we_d  = 1'b1;
                flg_d = szp_flags(acc_in & opnd_in, 1'b1, 1'b0);
            end
            OP_OR: begin
                res_d = acc_in | opnd_in;
                we_d  = 1'b1;
                flg_d = szp_flags(acc_in | opnd_in, 1'b0, 1'b0);
            end
            OP_XOR: begin
                res_d = acc_in ^ opnd_in;
                we_d  = 1'b1;
                flg_d = szp_flags(acc_in ^ opnd_in, 1'b0, 1'b0);
            end
            OP_INC, OP_DEC: begin
                res_d = step_sum;
                we_d  = 1'b1;
                flg_d = szp_flags(step_sum, step_hc, flg_q.cy);
            end
            OP_CMA: begin
                res_d = ~acc_in;
                we_d  = 1'b1;
            end
            OP_STC: flg_d.cy = 1'b1;
            OP_CMC: flg_d.cy = ~flg_q.cy;
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                res_d    = rot_res;
                we_d     = 1'b1;
                flg_d.cy = rot_cy;
            end
            OP_DAA: begin
                res_d = daa_res;
                we_d  = 1'b1;
                flg_d = szp_flags(daa_res, daa_ac, daa_cy);
            end
            OP_DAD: begin
                hlwe_d   = 1'b1;
                flg_d.cy = wide_cy;
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q  <= '0;
            result <= '0;
            res_we <= 1'b0;
            hl_out <= '0;
            hl_we  <= 1'b0;
        end else if (in_valid) begin
            flg_q  <= flg_d;
            result <= res_d;
            res_we <= we_d;
            hl_out <= hl_d;
            hl_we  <= hlwe_d;
        end else begin
            res_we <= 1'b0;
            hl_we  <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign flags     = flg_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [4:0] op_code,
    input logic       out_valid,
    input logic       res_we,
    input logic       hl_we,
    input logic [4:0] flags
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_logic_clears_cy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code >= 5'd4) && (op_code <= 5'd6) |=> !flags[0]);

    p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == 5'd7) |=> !res_we && !hl_we);

    p_step_keeps_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((op_code == 5'd8) || (op_code == 5'd9)) |=> flags[0] == $past(flags[0]));

    p_cma_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == 5'd10) |=> $stable(flags) && res_we);

    p_stc_sets_cy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == 5'd11) |=> flags[0] && !res_we);

    p_wide_only_cy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == 5'd18) |=> (flags[4:1] == $past(flags[4:1])) && hl_we && !res_we);

    p_undef_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code > 5'd18) |=> $stable(flags) && !res_we && !hl_we);

endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_test.sv
module acc_alu_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    res;
        bit    we;
        int    hl;
        bit    hwe;
        int    fl;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  opnd_in = '0;
    logic [15:0] pair_in = '0;
    logic [15:0] hl_in = '0;
    logic        out_valid;
    logic [7:0]  result;
    logic        res_we;
    logic [15:0] hl_out;
    logic        hl_we;
    logic [4:0]  flags;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    exp_t sbq[$];

    // bench model of the flag register
    int e_s = 0, e_z = 0, e_ac = 0, e_p = 0, e_cy = 0;

    acc_alu uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void set_szp(int r);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        e_s = (r >> 7) & 1;
        e_z = (r == 0);
        e_p = (ones % 2 == 0);
    endfunction

    task automatic drive(int op, int a, int b, int pr, int hl, string tag);
        exp_t e;
        int   t, c, lo, hi, t8;
        e.res = 0; e.we = 0; e.hl = 0; e.hwe = 0; e.tag = tag;
        case (op)
            0, 1: begin
                c = (op == 1) ? e_cy : 0;
                t = a + b + c;
                e_ac = ((a & 15) + (b & 15) + c) > 15;
                e_cy = t > 255;
                e.res = t & 255; e.we = 1; set_szp(e.res);
            end
            2, 3, 7: begin
                c = (op == 3) ? e_cy : 0;
                t = a - b - c;
                e_ac = ((a & 15) - (b & 15) - c) < 0;
                e_cy = t < 0;
                e.res = t & 255; e.we = (op != 7); set_szp(e.res);
            end
            4: begin e.res = a & b; e.we = 1; e_ac = 1; e_cy = 0; set_szp(e.res); end
            5: begin e.res = a | b; e.we = 1; e_ac = 0; e_cy = 0; set_szp(e.res); end
            6: begin e.res = a ^ b; e.we = 1; e_ac = 0; e_cy = 0; set_szp(e.res); end
            8: begin e.res = (b + 1) & 255; e.we = 1; e_ac = ((b & 15) + 1) > 15; set_szp(e.res); end
            9: begin e.res = (b - 1) & 255; e.we = 1; e_ac = ((b & 15) - 1) < 0; set_szp(e.res); end
            10: begin e.res = (~a) & 255; e.we = 1; end
            11: e_cy = 1;
            12: e_cy = !e_cy;
            13: begin e.res = ((a << 1) | (a >> 7)) & 255; e.we = 1; e_cy = (a >> 7) & 1; end
            14: begin e.res = (a >> 1) | ((a & 1) << 7); e.we = 1; e_cy = a & 1; end
            15: begin e.res = ((a << 1) & 255) | e_cy; e.we = 1; e_cy = (a >> 7) & 1; end
            16: begin e.res = (a >> 1) | (e_cy << 7); e.we = 1; e_cy = a & 1; end
            17: begin
                lo = ((a & 15) > 9) || (e_ac != 0);
                t  = a + (lo ? 6 : 0);
                e_ac = lo && (((a & 15) + 6) > 15);
                t8 = t & 255;
                hi = ((t8 >> 4) > 9) || (e_cy != 0) || (t > 255);
                e.res = (t8 + (hi ? 'h60 : 0)) & 255;
                e_cy = hi; e.we = 1; set_szp(e.res);
            end
            18: begin
                t = pr + hl;
                e.hl = t & 'hFFFF; e.hwe = 1; e_cy = t > 'hFFFF;
            end
            default: ;
        endcase
        e.fl = (e_s << 4) | (e_z << 3) | (e_ac << 2) | (e_p << 1) | e_cy;
        sbq.push_back(e);
        op_code  = 5'(op);
        acc_in   = 8'(a);
        opnd_in  = 8'(b);
        pair_in  = 16'(pr);
        hl_in    = 16'(hl);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // monitor: pop and compare each produced result
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sbq.size() == 0) begin
                vectors++; misses++;
                $display("FAIL R1: out_valid act=1 exp=0 (no operation pending)");
            end else begin
                exp_t e;
                bit bad;
                e = sbq.pop_front();
                vectors++;
                bad = (res_we != e.we) || (hl_we != e.hwe) || (int'(flags) != e.fl) ||
                      (e.we && int'(result) != e.res) || (e.hwe && int'(hl_out) != e.hl);
                if (bad) begin
                    misses++;
                    $display("FAIL %s: act res=%h we=%0d hl=%h hwe=%0d fl=%b exp res=%h we=%0d hl=%h hwe=%0d fl=%b",
                             e.tag, result, res_we, hl_out, hl_we, flags,
                             e.res[7:0], e.we, e.hl[15:0], e.hwe, e.fl[4:0]);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || flags !== 5'b0) begin
            misses++;
            $display("FAIL R1: reset act out_valid=%b flags=%b exp out_valid=0 flags=00000", out_valid, flags);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 add / add with carry
        drive(0, 'h3A, 'h27, 0, 0, "R3");
        drive(0, 'hFF, 'h01, 0, 0, "R3");
        drive(1, 'h10, 'h20, 0, 0, "R3");
        drive(1, 'h7F, 'h00, 0, 0, "R2");
        idle(2);
        // R4 subtract / borrow
        drive(2, 'h10, 'h01, 0, 0, "R4");
        drive(2, 'h05, 'h07, 0, 0, "R4");
        drive(3, 'h50, 'h10, 0, 0, "R4");
        drive(3, 'h00, 'h00, 0, 0, "R4");
        // R5 logic
        drive(11, 0, 0, 0, 0, "R9");
        drive(4, 'hF0, 'h3C, 0, 0, "R5");
        drive(11, 0, 0, 0, 0, "R9");
        drive(5, 'h00, 'h00, 0, 0, "R5");
        drive(6, 'hA5, 'h0F, 0, 0, "R5");
        idle(1);
        // R6 compare: less, equal, greater
        drive(7, 'h20, 'h30, 0, 0, "R6");
        drive(7, 'h42, 'h42, 0, 0, "R6");
        drive(7, 'h90, 'h10, 0, 0, "R6");
        // R7 inc/dec keep CY (set it, then wrap)
        drive(11, 0, 0, 0, 0, "R9");
        drive(8, 0, 'hFF, 0, 0, "R7");
        drive(9, 0, 'h00, 0, 0, "R7");
        drive(12, 0, 0, 0, 0, "R9");
        drive(8, 0, 'h0F, 0, 0, "R7");
        drive(9, 0, 'h01, 0, 0, "R7");
        // R9 complement accumulator
        drive(10, 'h5A, 0, 0, 0, "R9");
        // R8 rotates
        drive(13, 'h81, 0, 0, 0, "R8");
        drive(14, 'h01, 0, 0, 0, "R8");
        drive(15, 'h40, 0, 0, 0, "R8");
        drive(16, 'h02, 0, 0, 0, "R8");
        drive(15, 'h80, 0, 0, 0, "R8");
        drive(16, 'h00, 0, 0, 0, "R8");
        idle(2);
        // R10 decimal adjust after BCD adds
        drive(0, 'h38, 'h45, 0, 0, "R3");
        drive(17, 'h7D, 0, 0, 0, "R10");
        drive(0, 'h99, 'h99, 0, 0, "R3");
        drive(17, 'h32, 0, 0, 0, "R10");
        drive(0, 'h05, 'h03, 0, 0, "R3");
        drive(17, 'h08, 0, 0, 0, "R10");
        drive(0, 'h00, 'h00, 0, 0, "R3");
        drive(17, 'h9A, 0, 0, 0, "R10");
        // R11 wide add
        drive(2, 'h01, 'h02, 0, 0, "R4");
        drive(18, 0, 0, 'h1234, 'h0F0F, "R11");
        drive(18, 0, 0, 'hFFFF, 'h0002, "R11");
        // R12 undefined codes
        drive(25, 'h33, 'h44, 'h1, 'h1, "R12");
        drive(31, 'hFF, 'hFF, 0, 0, "R12");
        drive(0, 'h00, 'h00, 0, 0, "R12");
        idle(3);

        done = 1;
        if (sbq.size() != 0) begin
            vectors++; misses++;
            $display("FAIL R1: pending results act=%0d exp=0", sbq.size());
        end
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        misses++;
        $display("FAIL R1: watchdog expired act=running exp=finished");
        report();
    end

endmodule